// File: doc/BRIEF.md
# SDRAM Command Spacing Monitor

This block is a passive observer for a two-bank SDRAM command bus. On every rising clock edge it decodes the command from the chip-select, row strobe, column strobe and write-enable levels. It keeps, for each bank, whether a row is open and how many cycles have passed since that bank's last activate and last write. It never drives the bus. It sits next to a memory controller and reports any command that comes too soon after an earlier one, or that the target bank cannot accept in its current state.

Each rule has its own sticky flag. A code register holds the number of the rule that fired most recently, and a saturating counter adds up the rule hits. The minimum spacings are given in picoseconds and are turned into cycle thresholds by dividing by the clock period and rounding up. With the default 8000 ps period the thresholds are 3 cycles between activates in different banks, 10 between activates in one bank, 7 from an activate to its precharge, and 4 from an activate to a read or write. Writes are bursts of `BURST` data beats, and the write enable is sampled in the cycle of the write command. Only the sticky flags, the code and the counter are outputs. Reset or the `clr` input empties them.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After reset the flags, the code and the counter are all zero.
- R2: A command counts only when `cs_n` is low in that cycle. The (`ras_n`,`cas_n`,`we_n`) encodings are: activate 011, read 101, write 100, precharge 010 (`a10` high selects all banks), refresh 001, nop 111. Cycles with `cs_n` high are ignored.
- R3: An activate that comes fewer than ceil(RRD_PS/CLK_PS) cycles after an activate in another bank sets flag bit 0 (code 1).
- R4: An activate that comes fewer than ceil(RC_PS/CLK_PS) cycles after the previous activate of the same bank sets bit 1 (code 2).
- R5: A precharge that hits an open bank fewer than ceil(RAS_PS/CLK_PS) cycles after that bank's activate sets bit 2 (code 3).
- R6: A read or write to an open bank fewer than ceil(RCD_PS/CLK_PS) cycles after its activate sets bit 3 (code 4).
- R7: A precharge that hits an open bank fewer than `BURST` cycles after that bank's last write command sets bit 4 (code 5). The last write beat must come at least one cycle before the precharge.
- R8: A read or write to a closed bank, or an activate to an open bank, sets bit 5 (code 6).
- R9: Flags are sticky. When a cycle hits rules, the code becomes the lowest code hit in that cycle. `clr` empties the flags, the code and the counter, and hits in that same cycle are discarded.
- R10: The counter goes up by the number of distinct rules hit in a cycle and stops at its maximum value.
- R11: A precharge-all checks R5 and R7 against every open bank, and it closes every bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Empties flags, code and counter |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | All-banks qualifier for precharge |
| viol_flags | output | 6 | Sticky per-rule flags, bit k is code k+1 |
| viol_code | output | 3 | Code of the latest violation, 0 when none |
| viol_cnt | output | CNT_W | Saturating count of rule hits |

## Verification
The hardest situation to reach is a single cycle that breaks several rules across both banks at once. One example is a precharge-all that lands early for one bank while it is still inside the write recovery window of the other. In that cycle the lowest-code choice and the multi-hit counter increment both matter. Directed sequences open both banks at staggered times and then issue early precharge-all commands. A long run of random commands with occasional clears then reaches these combinations and drives the narrow counter into saturation. A behavioural model compares every output on every clock.

// File: rtl/sdrmon_pkg.sv
package sdrmon_pkg;
   localparam int NRULE  = 6;
   localparam int CODE_W = 3;

   typedef enum logic [2:0] {
      CMD_NONE, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_OTHER
   } cmd_e;

   // rule bit positions (code = bit + 1)
   localparam int RB_RRD   = 0;
   localparam int RB_RC    = 1;
   localparam int RB_RAS   = 2;
   localparam int RB_RCD   = 3;
   localparam int RB_WREC  = 4;
   localparam int RB_STATE = 5;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/sdrmon_decode.sv
module sdrmon_decode
   import sdrmon_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      cmd = CMD_NONE;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b111:  cmd = CMD_NONE;
            default: cmd = CMD_OTHER;
         endcase
      end
   end
endmodule

// File: rtl/sdrmon_bank.sv
module sdrmon_bank
   import sdrmon_pkg::*;
#(
   parameter int T_RC  = 10,
   parameter int T_RAS = 7,
   parameter int T_RCD = 4,
   parameter int BURST = 4,
   parameter int MAXT  = 10,
   parameter int CW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_e             cmd,
   input  logic             sel,
   input  logic             pre_all,
   input  logic             other_near,
   output logic [CW-1:0]    since_act,
   output logic [NRULE-1:0] hits
);
   localparam logic [CW-1:0] SAT = CW'(MAXT);

   logic [CW-1:0] since_wr;
   logic          open_q;
   logic          hit_act, hit_rw, hit_pre;

   assign hit_act = (cmd == CMD_ACT) && sel;
   assign hit_rw  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel;
   assign hit_pre = (cmd == CMD_PRE) && (sel || pre_all);

   always_comb begin
      hits           = '0;
      hits[RB_RRD]   = hit_act && other_near;
      hits[RB_RC]    = hit_act && (since_act < CW'(T_RC));
      hits[RB_RAS]   = hit_pre && open_q && (since_act < CW'(T_RAS));
      hits[RB_RCD]   = hit_rw && open_q && (since_act < CW'(T_RCD));
      hits[RB_WREC]  = hit_pre && open_q && (since_wr < CW'(BURST));
      hits[RB_STATE] = (hit_rw && !open_q) || (hit_act && open_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= SAT;
         since_wr  <= SAT;
         open_q    <= 1'b0;
      end else begin
         if (hit_act)              since_act <= CW'(1);
         else if (since_act < SAT) since_act <= since_act + CW'(1);
         if (hit_rw && cmd == CMD_WR) since_wr <= CW'(1);
         else if (since_wr < SAT)     since_wr <= since_wr + CW'(1);
         if (hit_act)      open_q <= 1'b1;
         else if (hit_pre) open_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sdrmon_flags.sv
module sdrmon_flags
   import sdrmon_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [NRULE-1:0]  hits,
   output logic [NRULE-1:0]  flags,
   output logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  cnt
);
   localparam logic [CNT_W:0] CMAX = {1'b0, {CNT_W{1'b1}}};

   logic [CODE_W-1:0] first;
   logic [CNT_W:0]    sum;

   always_comb begin
      first = '0;
      for (int k = NRULE - 1; k >= 0; k--)
         if (hits[k]) first = CODE_W'(k + 1);
      sum = {1'b0, cnt} + (CNT_W + 1)'($countones(hits));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         flags <= '0;
         code  <= '0;
         cnt   <= '0;
      end else if (|hits) begin
         flags <= flags | hits;
         code  <= first;
         cnt   <= (sum > CMAX) ? CMAX[CNT_W-1:0] : sum[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdrmon_pkg::*;
#(
   parameter int CLK_PS = 8000,
   parameter int RRD_PS = 20000,
   parameter int RC_PS  = 80000,
   parameter int RAS_PS = 50000,
   parameter int RCD_PS = 30000,
   parameter int BURST  = 4,
   parameter int NBANK  = 2,
   parameter int CNT_W  = 16,
   localparam int BA_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic              a10,
   output logic [NRULE-1:0]  viol_flags,
   output logic [CODE_W-1:0] viol_code,
   output logic [CNT_W-1:0]  viol_cnt
);
   localparam int T_RRD = ceil_div(RRD_PS, CLK_PS);
   localparam int T_RC  = ceil_div(RC_PS, CLK_PS);
   localparam int T_RAS = ceil_div(RAS_PS, CLK_PS);
   localparam int T_RCD = ceil_div(RCD_PS, CLK_PS);
   localparam int M1    = (T_RRD > T_RC) ? T_RRD : T_RC;
   localparam int M2    = (T_RAS > T_RCD) ? T_RAS : T_RCD;
   localparam int M3    = (M1 > M2) ? M1 : M2;
   localparam int MAXT  = (M3 > BURST) ? M3 : BURST;
   localparam int CW    = $clog2(MAXT + 1);

   if (CLK_PS < 1) begin : g_bad_clk
      $error("CLK_PS must be positive");
   end
   if (BURST < 1) begin : g_bad_burst
      $error("BURST must be at least 1");
   end
   if (NBANK < 2 || (1 << BA_W) != NBANK) begin : g_bad_bank
      $error("NBANK must be a power of two, at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   cmd_e             cmd;
   logic [CW-1:0]    since_act [NBANK];
   logic [NRULE-1:0] bank_hits [NBANK];
   logic [NBANK-1:0] other_near;
   logic [NRULE-1:0] all_hits;

   sdrmon_decode u_dec (
      .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
   );

   always_comb begin
      other_near = '0;
      for (int b = 0; b < NBANK; b++)
         for (int j = 0; j < NBANK; j++)
            if (j != b && since_act[j] < CW'(T_RRD)) other_near[b] = 1'b1;
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      sdrmon_bank #(
         .T_RC(T_RC), .T_RAS(T_RAS), .T_RCD(T_RCD),
         .BURST(BURST), .MAXT(MAXT), .CW(CW)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .cmd        (cmd),
         .sel        (ba == BA_W'(b)),
         .pre_all    (a10),
         .other_near (other_near[b]),
         .since_act  (since_act[b]),
         .hits       (bank_hits[b])
      );
   end

   always_comb begin
      all_hits = '0;
      for (int b = 0; b < NBANK; b++) all_hits = all_hits | bank_hits[b];
   end

   sdrmon_flags #(.CNT_W(CNT_W)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .hits (all_hits),
      .flags(viol_flags),
      .code (viol_code),
      .cnt  (viol_cnt)
   );
endmodule

// File: rtl/sdrmon_checker.sv
module sdrmon_checker
   import sdrmon_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic [NRULE-1:0]  viol_flags,
   input logic [CODE_W-1:0] viol_code,
   input logic [CNT_W-1:0]  viol_cnt
);
   logic rdwr_cmd;
   assign rdwr_cmd = !cs_n && ras_n && !cas_n;

   // R9: flags never drop without clr
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

   // R9: clr empties everything
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (viol_flags == '0 && viol_code == '0 && viol_cnt == '0));

   // R10: count never falls without clr
   p_cnt_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (viol_cnt >= $past(viol_cnt)));

   // R10: any flag implies a nonzero count and code
   p_cnt_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_flags != '0) |-> (viol_cnt != '0 && viol_code != '0));

   // R6: the activate-to-access flag only rises after a read or write
   p_rcd_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol_flags[RB_RCD]) |-> $past(rdwr_cmd));
endmodule

bind sdram_cmd_monitor sdrmon_checker #(.CNT_W(CNT_W)) u_sdrmon_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .viol_flags(viol_flags),
   .viol_code (viol_code),
   .viol_cnt  (viol_cnt)
);

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;
   localparam int CW = 4;
   localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4,
                  K_DES = 5, K_REF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0, clr = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [0:0] ba = '0;
   logic a10 = 1'b0;
   logic [5:0] viol_flags;
   logic [2:0] viol_code;
   logic [CW-1:0] viol_cnt;

   always #4 clk = ~clk;

   sdram_cmd_monitor #(.CNT_W(CW)) u_sdram_cmd_monitor (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
      .viol_flags(viol_flags), .viol_code(viol_code), .viol_cnt(viol_cnt)
   );

   int checks = 0, errors = 0;
   string cur_req = "R1";
   bit done = 0;

   // reference model state
   int cyc = 0;
   int last_act [2];
   int last_wr  [2];
   bit open_b   [2];
   int cur_kind = K_NOP;
   logic [5:0] ef = '0;
   int ecode = 0, ecnt = 0;

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_step();
      logic [5:0] eh = '0;
      cyc++;
      for (int b = 0; b < 2; b++) begin
         bit sel = (ba == b[0:0]);
         if (cur_kind == K_ACT && sel) begin
            if (cyc - last_act[1-b] < 3) eh[0] = 1;
            if (cyc - last_act[b] < 10) eh[1] = 1;
            if (open_b[b]) eh[5] = 1;
         end
         if ((cur_kind == K_RD || cur_kind == K_WR) && sel) begin
            if (!open_b[b]) eh[5] = 1;
            else if (cyc - last_act[b] < 4) eh[3] = 1;
         end
         if (cur_kind == K_PRE && (sel || a10) && open_b[b]) begin
            if (cyc - last_act[b] < 7) eh[2] = 1;
            if (cyc - last_wr[b] < 4) eh[4] = 1;
         end
      end
      for (int b = 0; b < 2; b++) begin
         bit sel = (ba == b[0:0]);
         if (cur_kind == K_ACT && sel) begin last_act[b] = cyc; open_b[b] = 1; end
         if (cur_kind == K_WR && sel) last_wr[b] = cyc;
         if (cur_kind == K_PRE && (sel || a10)) open_b[b] = 0;
      end
      if (clr) begin
         ef = '0; ecode = 0; ecnt = 0;
      end else if (eh != 0) begin
         ef = ef | eh;
         for (int k = 5; k >= 0; k--) if (eh[k]) ecode = k + 1;
         ecnt = ecnt + $countones(eh);
         if (ecnt > 15) ecnt = 15;
      end
   endtask

   // called at a negedge: drive, pass an edge, compare at next negedge
   task automatic do_cmd(input int kind, input int bank, input bit all, input bit c = 0);
      cur_kind = kind;
      ba = bank[0:0]; a10 = all; clr = c;
      cs_n = (kind == K_NOP || kind == K_DES) ? (kind == K_DES) : 1'b0;
      case (kind)
         K_ACT, K_DES: {ras_n, cas_n, we_n} = 3'b011;
         K_RD:         {ras_n, cas_n, we_n} = 3'b101;
         K_WR:         {ras_n, cas_n, we_n} = 3'b100;
         K_PRE:        {ras_n, cas_n, we_n} = 3'b010;
         K_REF:        {ras_n, cas_n, we_n} = 3'b001;
         default:      {ras_n, cas_n, we_n} = 3'b111;
      endcase
      @(posedge clk);
      #1 model_step();
      @(negedge clk);
      check(cur_req, int'(viol_flags), int'(ef), "flags");
      check(cur_req, int'(viol_code), ecode, "code");
      check(cur_req, int'(viol_cnt), ecnt, "count");
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) do_cmd(K_NOP, 0, 0);
   endtask

   task automatic close_all();
      idle(10);
      do_cmd(K_PRE, 0, 1);
      idle(10);
      do_cmd(K_NOP, 0, 0, 1);
   endtask

   initial begin
      last_act[0] = -1000; last_act[1] = -1000;
      last_wr[0]  = -1000; last_wr[1]  = -1000;
      open_b[0] = 0; open_b[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", int'(viol_flags), 0, "flags after reset");
      check("R1", int'(viol_code), 0, "code after reset");
      check("R1", int'(viol_cnt), 0, "count after reset");

      // R2: deselected activate is ignored, so the read hits a closed bank
      cur_req = "R2";
      do_cmd(K_DES, 0, 0); idle(12); do_cmd(K_REF, 0, 0);
      do_cmd(K_RD, 0, 0);
      check("R2", int'(viol_code), 6, "deselect ignored");
      close_all();

      // R3 / R4 / R6 boundaries
      cur_req = "R3";
      do_cmd(K_ACT, 0, 0); idle(1); do_cmd(K_ACT, 1, 0);   // 2 cycles: hit
      check("R3", int'(viol_code), 1, "rrd at 2");
      close_all();
      do_cmd(K_ACT, 0, 0); idle(2); do_cmd(K_ACT, 1, 0);   // 3 cycles: ok
      check("R3", int'(viol_flags), 0, "rrd at 3");
      close_all();
      cur_req = "R6";
      do_cmd(K_ACT, 1, 0); idle(2); do_cmd(K_WR, 1, 0);    // 3: hit
      check("R6", int'(viol_code), 4, "rcd at 3");
      do_cmd(K_RD, 1, 0);                                  // 4: ok
      close_all();
      cur_req = "R4";
      do_cmd(K_ACT, 0, 0); idle(6); do_cmd(K_PRE, 0, 0);   // 7: ok for R5
      check("R5", int'(viol_flags), 0, "ras at 7");
      idle(1); do_cmd(K_ACT, 0, 0);                        // 9: rc hit
      check("R4", int'(viol_code), 2, "rc at 9");
      close_all();

      // R5 / R7 / R8
      cur_req = "R5";
      do_cmd(K_ACT, 0, 0); idle(5); do_cmd(K_PRE, 0, 0);   // 6: hit
      check("R5", int'(viol_code), 3, "ras at 6");
      close_all();
      cur_req = "R7";
      do_cmd(K_ACT, 1, 0); idle(8); do_cmd(K_WR, 1, 0); idle(2);
      do_cmd(K_PRE, 1, 0);                                  // 3 after write
      check("R7", int'(viol_code), 5, "write recovery");
      close_all();
      cur_req = "R8";
      do_cmd(K_ACT, 0, 0); idle(11); do_cmd(K_ACT, 0, 0);
      check("R8", int'(viol_code), 6, "act to open bank");
      close_all();

      // R11: precharge-all over two open banks, one early, one with a write
      cur_req = "R11";
      do_cmd(K_ACT, 0, 0); idle(3); do_cmd(K_ACT, 1, 0); idle(3);
      do_cmd(K_WR, 0, 0); do_cmd(K_PRE, 0, 1);
      check("R11", int'(viol_flags), 6'b010100, "pre-all two rules");
      check("R10", int'(viol_cnt), 2, "two rules one cycle");
      do_cmd(K_RD, 1, 0);
      check("R11", int'(viol_code), 6, "bank1 closed by pre-all");
      // R9: clr in a violating cycle
      cur_req = "R9";
      do_cmd(K_RD, 0, 0, 1);
      check("R9", int'(viol_flags), 0, "clr wins");
      close_all();

      // R10: random traffic, saturating count
      cur_req = "R10";
      for (int i = 0; i < 3000; i++)
         do_cmd($urandom_range(0, 6), $urandom_range(0, 1),
                $urandom_range(0, 3) == 0, $urandom_range(0, 60) == 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule